// File: doc/BRIEF.md
# MDIO Management Master

This block runs clause 22 management frames towards external PHYs over a two-wire serial management bus: a clock output driven by the master and a bidirectional data line. Software programs a control register with the management clock divider and a preamble switch. It then writes one 32-bit command word whose upper half already holds the frame header in the order the bits go out on the wire. The block sends that word most significant bit first, optionally after a run of ones. For a read it releases the data line during turnaround and writes the sixteen returned bits back into the low half of the same register.

Completion is reported by a sticky flag that software clears by writing a one to it. A busy flag can be polled alongside it. The data line is split into an output value, an output enable and an input, and the pad tristate is built outside the block.

Top module: `mdio_master`

## Requirements
- R1: After reset, all readable registers return zero, the management clock is low and the data output enable is low.
- R2: While a frame runs, the management clock period is 2*(div+1) system clocks, where div is control register bits [6:0] at register index 0. The clock stays low whenever no frame is running.
- R3: With control bit 7 set, 32 ones are sent before the frame. With bit 7 clear, the first bit on the wire is command bit 31.
- R4: The command register is at index 1. In a write frame (bits [31:28] = 0x5, bit 29 = 0), command bits 31 down to 0 are sent in that order and the output enable stays high for the whole frame.
- R5: In a read frame (bits [31:28] = 0x6, bit 29 = 1), the output enable goes low from the bit carrying command bit 16 (the second turnaround bit) to the end of the frame. The 16 sampled bits land MSB first in bits [15:0], and bits [31:16] keep their written values.
- R6: The data output changes only after a falling edge of the management clock and is stable across the rising edge, at which the input is also sampled.
- R7: The status register is at index 2. Its bit 0 is set when a frame ends and stays set until software writes 1 to it; writing 0 leaves it set.
- R8: Status bit 1 reads 1 while a frame runs. A command write during that time is ignored: neither the frame nor the register contents change.
- R9: The control register reads back the divider in bits [6:0] and the preamble switch in bit 7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register index: 0 control, 1 command, 2 status |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line input |

## Verification
The hardest case to reach is the one where the input sample and the output change sit closest together: a zero divider makes each clock phase one system clock long, and a read frame then needs the attached PHY to drive each bit right after a falling edge so that it is captured at the next rising edge. The bench models a PHY that drives the data line on every falling edge of the management clock. It sweeps small and zero dividers with and without preamble for both frame types. In one frame it issues a second command mid-flight to confirm that the write is ignored.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
   localparam int FRAME_W  = 32;
   localparam int DATA_W   = 16;
   localparam int REG_AW   = 2;
   localparam int PRE_BIT  = 7;
   localparam int RD_BIT   = 29;
   localparam logic [REG_AW-1:0] IDX_CTRL = 2'd0;
   localparam logic [REG_AW-1:0] IDX_CMD  = 2'd1;
   localparam logic [REG_AW-1:0] IDX_STAT = 2'd2;
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
   parameter int DIV_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [DIV_W-1:0] div,
   output logic             mdc,
   output logic             rise_evt,
   output logic             fall_evt
);
   logic [DIV_W-1:0] cnt_q;
   logic             wrap;

   assign wrap     = en && (cnt_q == div);
   assign rise_evt = wrap && !mdc;
   assign fall_evt = wrap && mdc;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         mdc   <= 1'b0;
      end else if (!en) begin
         cnt_q <= '0;
         mdc   <= 1'b0;
      end else if (wrap) begin
         cnt_q <= '0;
         mdc   <= !mdc;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/mdio_engine.sv
module mdio_engine
   import mdio_pkg::*;
#(
   parameter int PRE_LEN = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic               pre_en,
   input  logic [FRAME_W-1:0] cmd_in,
   input  logic               rise_evt,
   input  logic               fall_evt,
   input  logic               mdio_i,
   output logic               busy,
   output logic               done_pulse,
   output logic [FRAME_W-1:0] cmd_q,
   output logic               mdio_o,
   output logic               mdio_oe
);
   localparam int TOT   = FRAME_W + PRE_LEN;
   localparam int IDX_W = $clog2(TOT + 1);
   localparam int BIT_W = $clog2(FRAME_W);

   logic [IDX_W-1:0] idx_q;
   logic [IDX_W-1:0] first_idx;
   logic             in_pre;
   logic             is_read;
   logic [BIT_W-1:0] bsel;

   generate
      if (PRE_LEN > 0) begin : g_pre
         assign first_idx = pre_en ? IDX_W'(TOT - 1) : IDX_W'(FRAME_W - 1);
         assign in_pre    = idx_q >= IDX_W'(FRAME_W);
      end else begin : g_nopre
         logic unused_pre;
         assign unused_pre = pre_en;
         assign first_idx  = IDX_W'(FRAME_W - 1);
         assign in_pre     = 1'b0;
      end
   endgenerate

   assign bsel       = idx_q[BIT_W-1:0];
   assign is_read    = cmd_q[RD_BIT];
   assign mdio_o     = (!busy || in_pre) ? 1'b1 : cmd_q[bsel];
   assign mdio_oe    = busy && !(is_read && !in_pre && idx_q <= IDX_W'(DATA_W));
   assign done_pulse = busy && fall_evt && (idx_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_q <= '0;
         idx_q <= '0;
         busy  <= 1'b0;
      end else if (start && !busy) begin
         cmd_q <= cmd_in;
         idx_q <= first_idx;
         busy  <= 1'b1;
      end else if (busy) begin
         if (rise_evt && is_read && !in_pre && idx_q < IDX_W'(DATA_W))
            cmd_q[bsel] <= mdio_i;
         if (fall_evt) begin
            if (idx_q == '0) busy <= 1'b0;
            else             idx_q <= idx_q - 1'b1;
         end
      end
   end
endmodule

// File: rtl/mdio_master.sv
module mdio_master
   import mdio_pkg::*;
#(
   parameter int DIV_W   = 7,
   parameter int PRE_LEN = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   output logic              mdc,
   output logic              mdio_o,
   output logic              mdio_oe,
   input  logic              mdio_i
);
   generate
      if (DIV_W < 1 || DIV_W > PRE_BIT) begin : g_bad_div
         $error("DIV_W must be in 1..7");
      end
      if (PRE_LEN < 0 || PRE_LEN > 64) begin : g_bad_pre
         $error("PRE_LEN must be in 0..64");
      end
   endgenerate

   logic [DIV_W-1:0]   div_q;
   logic               pre_q;
   logic               done_q;
   logic               busy_w;
   logic               done_pulse;
   logic [FRAME_W-1:0] cmd_w;
   logic               rise_evt, fall_evt;
   logic               wr_ctrl, wr_cmd, clr_done;

   assign wr_ctrl  = reg_wr && reg_addr == IDX_CTRL;
   assign wr_cmd   = reg_wr && reg_addr == IDX_CMD;
   assign clr_done = reg_wr && reg_addr == IDX_STAT && reg_wdata[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_q  <= '0;
         pre_q  <= 1'b0;
         done_q <= 1'b0;
      end else begin
         if (wr_ctrl) begin
            div_q <= reg_wdata[DIV_W-1:0];
            pre_q <= reg_wdata[PRE_BIT];
         end
         if (done_pulse)    done_q <= 1'b1;
         else if (clr_done) done_q <= 1'b0;
      end
   end

   mdio_clkgen #(.DIV_W(DIV_W)) clkgen_i (
      .clk(clk), .rst_n(rst_n), .en(busy_w), .div(div_q),
      .mdc(mdc), .rise_evt(rise_evt), .fall_evt(fall_evt)
   );

   mdio_engine #(.PRE_LEN(PRE_LEN)) engine_i (
      .clk(clk), .rst_n(rst_n), .start(wr_cmd), .pre_en(pre_q),
      .cmd_in(reg_wdata), .rise_evt(rise_evt), .fall_evt(fall_evt),
      .mdio_i(mdio_i), .busy(busy_w), .done_pulse(done_pulse),
      .cmd_q(cmd_w), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
   );

   always_comb begin
      reg_rdata = '0;
      unique case (reg_addr)
         IDX_CTRL: begin
            reg_rdata[DIV_W-1:0] = div_q;
            reg_rdata[PRE_BIT]   = pre_q;
         end
         IDX_CMD:  reg_rdata = cmd_w;
         IDX_STAT: reg_rdata[1:0] = {busy_w, done_q};
         default:  reg_rdata = '0;
      endcase
   end
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        mdc,
   input logic        mdio_o,
   input logic        mdio_oe,
   input logic        busy,
   input logic        done,
   input logic [15:0] cmd_hi,
   input logic        is_read
);
   // R2: clock parked low between frames
   p_mdc_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mdc);
   // R4: the line is never driven while idle; writes drive throughout
   p_oe_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mdio_oe);
   p_oe_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
      busy && !is_read |-> mdio_oe);
   // R6: driven value unchanged across a rising clock edge
   p_stable_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mdc) && mdio_oe |-> $stable(mdio_o));
   // R7: end of frame leaves the completion flag set
   p_done_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);
   // R8, R5: header half untouched while a frame runs
   p_hdr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(cmd_hi));
endmodule

bind mdio_master mdio_master_chk chk_i (
   .clk(clk), .rst_n(rst_n), .mdc(mdc), .mdio_o(mdio_o),
   .mdio_oe(mdio_oe), .busy(busy_w), .done(done_q),
   .cmd_hi(cmd_w[31:16]), .is_read(cmd_w[29])
);

// File: tb/mdio_master_tb_top.sv
`timescale 1ns/1ps
module mdio_master_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [1:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        mdc, mdio_o, mdio_oe;
   logic        mdio_i = 1'b0;

   int checks = 0;
   int fails  = 0;
   int cycles = 0;

   logic [31:0] cur_cmd = '0;
   logic [15:0] cur_pdat = '0;
   bit          cur_pre = 0;
   int          rises = 0;
   int          bit_bad = 0;
   int          oe_bad = 0;
   longint      last_t = 0;
   longint      period_t = 0;

   always #4 clk = !clk;

   mdio_master dut_i (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
      .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
   );

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         fails++;
         $display("FAIL watchdog: act=%0d exp<=150000 cycles", cycles);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   // wire monitor: value and enable captured at every rising edge
   always @(posedge mdc) begin
      int  f;
      logic eb, eo;
      f = rises - (cur_pre ? 32 : 0);
      if (f < 0) begin
         eb = 1'b1; eo = 1'b1;
      end else if (f <= 31) begin
         eb = cur_cmd[31-f];
         eo = !(cur_cmd[29] && f >= 15);
      end else begin
         eb = 1'bx; eo = 1'bx;
         bit_bad++;
      end
      if (f <= 31) begin
         if (mdio_oe !== eo) oe_bad++;
         if (eo && mdio_o !== eb) bit_bad++;
      end
      if (rises > 0) period_t = $time - last_t;
      last_t = $time;
      rises++;
   end

   // PHY model: drives read data after each falling edge
   always @(negedge mdc) begin
      int f;
      f = rises - (cur_pre ? 32 : 0);
      if (cur_cmd[29] && f >= 16 && f <= 31) mdio_i = cur_pdat[31-f];
   end

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic run_txn(input int div, input bit pre, input logic [31:0] cmd,
                          input logic [15:0] pdat, input bit poke);
      logic [31:0] v;
      logic [31:0] exp_cmd;
      int guard;
      wr(2'd0, {24'b0, pre, 7'(div)});
      rd(2'd0, v);
      chk(v == {24'b0, pre, 7'(div)}, "R9 ctrl readback", v, {24'b0, pre, 7'(div)});
      cur_cmd = cmd; cur_pdat = pdat; cur_pre = pre;
      rises = 0; bit_bad = 0; oe_bad = 0; period_t = 0;
      wr(2'd1, cmd);
      rd(2'd2, v);
      chk(v[1] == 1'b1, "R8 busy while running", v[1], 1);
      if (poke) begin
         repeat (3) @(negedge clk);
         wr(2'd1, ~cmd);
      end
      guard = 0;
      v = 32'h2;
      while (v[1] && guard < 20000) begin
         rd(2'd2, v);
         guard++;
      end
      chk(v == 32'h1, "R7 done set, busy clear", v, 1);
      chk(rises == (pre ? 64 : 32), "R3 bit count incl. preamble", rises, pre ? 64 : 32);
      chk(bit_bad == 0, "R4/R6 wire bits at rising edge", bit_bad, 0);
      chk(oe_bad == 0, "R4/R5 output enable pattern", oe_bad, 0);
      chk(period_t == 16 * (div + 1), "R2 mdc period ns", period_t, 16 * (div + 1));
      chk(mdc == 1'b0 && mdio_oe == 1'b0, "R2 idle clock and enable low", {mdc, mdio_oe}, 0);
      exp_cmd = cmd[29] ? {cmd[31:16], pdat} : cmd;
      rd(2'd1, v);
      chk(v == exp_cmd, poke ? "R8 busy write ignored" : "R5 command readback", v, exp_cmd);
      wr(2'd2, 32'h0);
      rd(2'd2, v);
      chk(v[0] == 1'b1, "R7 write 0 keeps flag", v[0], 1);
      wr(2'd2, 32'h1);
      rd(2'd2, v);
      chk(v[0] == 1'b0, "R7 write 1 clears flag", v[0], 0);
   endtask

   initial begin
      logic [31:0] v;
      int divs[4] = '{0, 1, 2, 5};
      int k = 0;
      repeat (3) @(negedge clk);
      chk(mdc == 1'b0 && mdio_oe == 1'b0, "R1 pins in reset", {mdc, mdio_oe}, 0);
      rst_n = 1'b1;
      for (int a = 0; a < 3; a++) begin
         rd(2'(a), v);
         chk(v == 32'h0, "R1 register reset value", v, 0);
      end
      foreach (divs[d]) begin
         for (int p = 0; p < 2; p++) begin
            for (int r = 0; r < 2; r++) begin
               logic [4:0]  phy, rg;
               logic [15:0] dat, pd;
               logic [31:0] c;
               phy = 5'((k * 7 + 3) % 32);
               rg  = 5'((k * 11 + 1) % 32);
               dat = 16'hA5C3 ^ 16'(k * 16'h1111);
               pd  = 16'h3C5A + 16'(k * 16'h0913);
               c   = {(r != 0) ? 4'h6 : 4'h5, phy, rg, 2'b10, (r != 0) ? 16'h0 : dat};
               run_txn(divs[d], p[0], c, pd, 1'b0);
               k++;
            end
         end
      end
      // R8: overlapping command on both frame kinds
      run_txn(1, 1'b0, {4'h5, 5'd9, 5'd4, 2'b10, 16'hBEEF}, 16'h0, 1'b1);
      run_txn(0, 1'b1, {4'h6, 5'd2, 5'd30, 2'b10, 16'h0}, 16'h8001, 1'b1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule